// File: doc/BRIEF.md
# Configuration Header with Base Address Decode

This block holds the 256-byte configuration register space of one bus endpoint. A configuration decoder drives a single dword-addressed port with per-byte enables. Writes land byte by byte, except on a small set of identity bytes that are read-only. Reads return the addressed dword, assembled little-endian. The identity values (vendor, device, revision, programming interface, class, header type, interrupt pin) are parameters.

Up to six base address registers sit at dwords 4 to 9. Each has a fixed power-of-two size and a fixed type (I/O or memory). A size of zero means the register is absent. A full-dword write to a present BAR stores the data with the size bits cleared and the type bit forced. The block keeps, for each BAR, a decoded base address and a valid flag. These are recomputed from the command register enables and from range rules that differ for I/O and memory.

The decoded mapping changes only after a trigger: a BAR write, or any write whose enabled bytes cover the two command register bytes. When a mapping changes, the BAR's remap strobe pulses for one cycle. The previous base and valid flag are presented alongside the strobe, so the surrounding logic can tear down the old window before opening the new one.

Top module: `cfg_header_bar`

## Requirements
- R1: After reset, identity bytes hold their parameter values, all other bytes read 0 except byte 0 of each present I/O BAR, which reads 1 (the I/O type bit). All decoded bases are 0, all valid flags are 0 and no remap strobe is high.
- R2: Writes to byte offsets 0x00–0x03, 0x08–0x0B, 0x0E and 0x3D have no effect. Other enabled bytes of the same access are still written.
- R3: A write with all four byte enables set to a present BAR (dword 4+n, n = 0..5) stores (data & ~(size−1)) | type, where type is 1 for I/O and 0 for memory in bit 0.
- R4: A write with fewer than four byte enables to a BAR dword, and any write to an absent BAR, stores the enabled bytes unchanged.
- R5: Command bit 0 (byte offset 0x04) enables I/O decoding and bit 1 enables memory decoding. With the matching bit clear, the mapping is invalid.
- R6: An I/O mapping with base b = raw & ~(size−1) is valid only if b ≠ 0, b+size−1 does not exceed 0xFFFFFFFF, and b+size−1 < 0x10000.
- R7: A memory mapping is valid only if b ≠ 0 and b+size−1 < 0xFFFFFFFF.
- R8: Mappings are recomputed after a full-dword write to a present BAR, or after a write to dword 1 with byte enable 0 or 1 set. The new base and valid flag appear one clock after the write edge. Without such a trigger they hold.
- R9: An invalid mapping reports base 0. A BAR's remap strobe is high for exactly one cycle when a recomputation changes its base or valid flag. During that cycle, the previous base and valid flag are presented on the old-mapping outputs.
- R10: Read data for dword d has byte offset 4d+k in bits [8k+7:8k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_wr | input | 1 | Write strobe for the current access |
| acc_dw | input | 6 | Dword index of the access |
| acc_be | input | 4 | Byte enables, bit k for byte 4*acc_dw+k |
| acc_wdata | input | 32 | Write data, little-endian |
| rd_data | output | 32 | Dword at acc_dw, little-endian |
| bar_base | output | 6x32 | Decoded base per BAR (0 when invalid) |
| bar_valid | output | 6 | Mapping valid per BAR |
| bar_remap | output | 6 | One-cycle strobe when a BAR's mapping changes |
| bar_old_base | output | 6x32 | Base before the last recomputation |
| bar_old_valid | output | 6 | Valid flag before the last recomputation |

## Verification
The assertions take for granted that the write strobe is low while reset is applied and is a known level afterwards. They also assume each nonzero BAR size is a power of two at least 4 for I/O and at least 16 for memory, so the type bit always lies inside the cleared size bits. The bench changes inputs only on falling edges and keeps the write strobe low through reset. It uses only the default BAR sizes, which meet these limits. The bench sweeps every dword with full and partial enable patterns, and places BAR bases on both sides of each range limit with the command enables on and off.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

    localparam int CFG_BYTES  = 256;
    localparam int CFG_DWORDS = CFG_BYTES / 4;
    localparam int DW_AW      = $clog2(CFG_DWORDS);
    localparam int NUM_BARS   = 6;
    localparam int BAR_DW0    = 4;
    localparam int CMD_DW     = 1;
    localparam logic [31:0] IO_SPACE_LIMIT = 32'h0001_0000;

    typedef logic [7:0]  cfg_byte_t;
    typedef logic [31:0] cfg_word_t;

    typedef struct packed {
        logic      valid;
        cfg_word_t base;
    } bar_map_t;

    typedef struct packed {
        logic io_en;
        logic mem_en;
    } dec_enable_t;

    // Identity bytes that ignore writes.
    function automatic logic byte_is_ro(input logic [7:0] off);
        case (off)
            8'h00, 8'h01, 8'h02, 8'h03,
            8'h08, 8'h09, 8'h0A, 8'h0B,
            8'h0E, 8'h3D: return 1'b1;
            default:      return 1'b0;
        endcase
    endfunction

    // Decoded window of one BAR from its raw register, size, type and enables.
    function automatic bar_map_t decode_bar(input cfg_word_t raw, input cfg_word_t size,
                                            input logic is_io, input dec_enable_t en);
        cfg_word_t   b;
        logic [32:0] last;
        logic        ok;
        bar_map_t    res;
        b    = raw & ~(size - 32'd1);
        last = {1'b0, b} + {1'b0, size} - 33'd1;
        if (is_io)
            ok = en.io_en && (b != '0) && !last[32] && (last[31:0] < IO_SPACE_LIMIT);
        else
            ok = en.mem_en && (b != '0) && !last[32] && (last[31:0] != 32'hFFFF_FFFF);
        res.valid = ok;
        res.base  = ok ? b : '0;
        return res;
    endfunction

endpackage

// File: rtl/cfg_byte_array.sv
module cfg_byte_array
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1AF4,
    parameter logic [15:0] DEVICE_ID   = 16'h5A3C,
    parameter logic [7:0]  REVISION    = 8'h02,
    parameter logic [7:0]  PROG_IF     = 8'h00,
    parameter logic [15:0] CLASS_CODE  = 16'h0200,
    parameter logic [7:0]  HEADER_TYPE = 8'h00,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE =
        {32'h0, 32'h0010_0000, 32'h10, 32'h0, 32'h1000, 32'h20},
    parameter logic [NUM_BARS-1:0] BAR_IS_IO = 6'b001001
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       acc_wr,
    input  logic [DW_AW-1:0]           acc_dw,
    input  logic [3:0]                 acc_be,
    input  cfg_word_t                  acc_wdata,
    output cfg_word_t                  rd_data,
    output dec_enable_t                cmd_en,
    output logic [NUM_BARS-1:0][31:0]  bar_raw,
    output logic                       recalc
);

    cfg_byte_t mem [CFG_BYTES];

    function automatic cfg_byte_t reset_byte(input int off);
        cfg_byte_t v;
        case (off)
            0:  v = VENDOR_ID[7:0];
            1:  v = VENDOR_ID[15:8];
            2:  v = DEVICE_ID[7:0];
            3:  v = DEVICE_ID[15:8];
            8:  v = REVISION;
            9:  v = PROG_IF;
            10: v = CLASS_CODE[7:0];
            11: v = CLASS_CODE[15:8];
            14: v = HEADER_TYPE;
            61: v = INT_PIN;
            default: v = '0;
        endcase
        for (int b = 0; b < NUM_BARS; b++) begin
            if (off == (BAR_DW0 + b) * 4 && BAR_SIZE[b] != '0 && BAR_IS_IO[b])
                v = 8'h01;
        end
        return v;
    endfunction

    logic       bar_hit;
    cfg_word_t  bar_word;
    logic [7:0] lane_off  [4];
    logic       lane_we   [4];
    cfg_byte_t  lane_data [4];

    always_comb begin
        bar_hit  = 1'b0;
        bar_word = acc_wdata;
        for (int b = 0; b < NUM_BARS; b++) begin
            if (acc_wr && acc_be == 4'hF && acc_dw == DW_AW'(BAR_DW0 + b) &&
                BAR_SIZE[b] != '0) begin
                bar_hit  = 1'b1;
                bar_word = (acc_wdata & ~(BAR_SIZE[b] - 32'd1)) | {31'b0, BAR_IS_IO[b]};
            end
        end
        for (int k = 0; k < 4; k++) begin
            lane_off[k]  = {acc_dw, 2'(k)};
            lane_we[k]   = acc_wr && (bar_hit || (acc_be[k] && !byte_is_ro(lane_off[k])));
            lane_data[k] = bar_word[8*k +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CFG_BYTES; i++)
                mem[i] <= reset_byte(i);
        end else begin
            for (int k = 0; k < 4; k++)
                if (lane_we[k]) mem[lane_off[k]] <= lane_data[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) recalc <= 1'b0;
        else     recalc <= acc_wr && (bar_hit || (acc_dw == DW_AW'(CMD_DW) && |acc_be[1:0]));
    end

    always_comb begin
        for (int k = 0; k < 4; k++)
            rd_data[8*k +: 8] = mem[{acc_dw, 2'(k)}];
        cmd_en.io_en  = mem[CMD_DW*4][0];
        cmd_en.mem_en = mem[CMD_DW*4][1];
        for (int b = 0; b < NUM_BARS; b++)
            for (int k = 0; k < 4; k++)
                bar_raw[b][8*k +: 8] = mem[8'((BAR_DW0 + b) * 4 + k)];
    end

    logic [79:0] ro_snapshot;
    assign ro_snapshot = {mem[0], mem[1], mem[2], mem[3], mem[8], mem[9],
                          mem[10], mem[11], mem[14], mem[61]};

    a_r2_ro_bytes_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(ro_snapshot))
        else $error("identity byte changed after reset");

    a_r8_recalc_needs_write: assert property (@(posedge clk) disable iff (rst)
        !acc_wr |=> !recalc)
        else $error("recompute without a write");

endmodule

// File: rtl/cfg_bar_map.sv
module cfg_bar_map
    import cfg_hdr_pkg::*;
#(
    parameter logic [31:0] SIZE  = 32'h1000,
    parameter bit          IS_IO = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        recalc,
    input  cfg_word_t   raw,
    input  dec_enable_t en,
    output cfg_word_t   base,
    output logic        valid,
    output logic        remap,
    output cfg_word_t   old_base,
    output logic        old_valid
);

    bar_map_t next_map, cur_map, prev_map;
    logic     remap_q;

    assign next_map = decode_bar(raw, SIZE, IS_IO, en);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_map  <= '0;
            prev_map <= '0;
            remap_q  <= 1'b0;
        end else begin
            remap_q <= 1'b0;
            if (recalc) begin
                prev_map <= cur_map;
                cur_map  <= next_map;
                remap_q  <= (next_map != cur_map);
            end
        end
    end

    assign base      = cur_map.base;
    assign valid     = cur_map.valid;
    assign remap     = remap_q;
    assign old_base  = prev_map.base;
    assign old_valid = prev_map.valid;

    a_r9_remap_shows_change: assert property (@(posedge clk) disable iff (rst)
        remap |-> (base != old_base || valid != old_valid))
        else $error("remap without a change");

    a_r9_remap_after_recalc: assert property (@(posedge clk) disable iff (rst)
        remap |-> $past(recalc))
        else $error("remap without recompute");

    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        !recalc |=> ($stable(base) && $stable(valid)))
        else $error("mapping moved without trigger");

    a_r9_invalid_base_zero: assert property (@(posedge clk) disable iff (rst)
        !valid |-> base == '0)
        else $error("invalid mapping with nonzero base");

    generate
        if (IS_IO) begin : g_io_chk
            a_r6_io_window: assert property (@(posedge clk) disable iff (rst)
                valid |-> (base != '0 && ({1'b0, base} + {1'b0, SIZE} - 33'd1) < 33'h1_0000))
                else $error("I/O window out of range");
        end else begin : g_mem_chk
            a_r7_mem_window: assert property (@(posedge clk) disable iff (rst)
                valid |-> (base != '0 && ({1'b0, base} + {1'b0, SIZE} - 33'd1) < 33'h0_FFFF_FFFF))
                else $error("memory window out of range");
        end
    endgenerate

endmodule

// File: rtl/cfg_header_bar.sv
module cfg_header_bar
    import cfg_hdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1AF4,
    parameter logic [15:0] DEVICE_ID   = 16'h5A3C,
    parameter logic [7:0]  REVISION    = 8'h02,
    parameter logic [7:0]  PROG_IF     = 8'h00,
    parameter logic [15:0] CLASS_CODE  = 16'h0200,
    parameter logic [7:0]  HEADER_TYPE = 8'h00,
    parameter logic [7:0]  INT_PIN     = 8'h01,
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE =
        {32'h0, 32'h0010_0000, 32'h10, 32'h0, 32'h1000, 32'h20},
    parameter logic [NUM_BARS-1:0] BAR_IS_IO = 6'b001001
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_wr,
    input  logic [5:0]                acc_dw,
    input  logic [3:0]                acc_be,
    input  logic [31:0]               acc_wdata,
    output logic [31:0]               rd_data,
    output logic [NUM_BARS-1:0][31:0] bar_base,
    output logic [NUM_BARS-1:0]       bar_valid,
    output logic [NUM_BARS-1:0]       bar_remap,
    output logic [NUM_BARS-1:0][31:0] bar_old_base,
    output logic [NUM_BARS-1:0]       bar_old_valid
);

    dec_enable_t               cmd_en;
    logic [NUM_BARS-1:0][31:0] bar_raw;
    logic                      recalc;

    cfg_byte_array #(
        .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
        .PROG_IF(PROG_IF), .CLASS_CODE(CLASS_CODE), .HEADER_TYPE(HEADER_TYPE),
        .INT_PIN(INT_PIN), .BAR_SIZE(BAR_SIZE), .BAR_IS_IO(BAR_IS_IO)
    ) u_bytes (
        .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_dw(acc_dw), .acc_be(acc_be),
        .acc_wdata(acc_wdata), .rd_data(rd_data), .cmd_en(cmd_en),
        .bar_raw(bar_raw), .recalc(recalc)
    );

    generate
        for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
            if (BAR_SIZE[g] != '0) begin : g_present
                cfg_bar_map #(.SIZE(BAR_SIZE[g]), .IS_IO(BAR_IS_IO[g])) u_map (
                    .clk(clk), .rst(rst), .recalc(recalc), .raw(bar_raw[g]), .en(cmd_en),
                    .base(bar_base[g]), .valid(bar_valid[g]), .remap(bar_remap[g]),
                    .old_base(bar_old_base[g]), .old_valid(bar_old_valid[g])
                );
            end else begin : g_absent
                assign bar_base[g]      = '0;
                assign bar_valid[g]     = 1'b0;
                assign bar_remap[g]     = 1'b0;
                assign bar_old_base[g]  = '0;
                assign bar_old_valid[g] = 1'b0;
            end
        end
    endgenerate

endmodule

// File: tb/cfg_header_bar_tb.sv
module cfg_header_bar_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] P_VEN  = 16'h1AF4;
    localparam logic [15:0] P_DEV  = 16'h5A3C;
    localparam logic [7:0]  P_REV  = 8'h02;
    localparam logic [7:0]  P_PIF  = 8'h11;
    localparam logic [15:0] P_CLS  = 16'h0200;
    localparam logic [7:0]  P_HDR  = 8'h80;
    localparam logic [7:0]  P_PIN  = 8'h01;
    localparam logic [5:0][31:0] SZ =
        {32'h0, 32'h0010_0000, 32'h10, 32'h0, 32'h1000, 32'h20};
    localparam logic [5:0] ISIO = 6'b001001;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic acc_wr = 1'b0;
    logic [5:0] acc_dw = '0;
    logic [3:0] acc_be = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic [5:0][31:0] bar_base, bar_old_base;
    logic [5:0] bar_valid, bar_remap, bar_old_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_header_bar #(
        .VENDOR_ID(P_VEN), .DEVICE_ID(P_DEV), .REVISION(P_REV), .PROG_IF(P_PIF),
        .CLASS_CODE(P_CLS), .HEADER_TYPE(P_HDR), .INT_PIN(P_PIN),
        .BAR_SIZE(SZ), .BAR_IS_IO(ISIO)
    ) u_dut (
        .clk(clk), .rst(rst), .acc_wr(acc_wr), .acc_dw(acc_dw), .acc_be(acc_be),
        .acc_wdata(acc_wdata), .rd_data(rd_data), .bar_base(bar_base),
        .bar_valid(bar_valid), .bar_remap(bar_remap), .bar_old_base(bar_old_base),
        .bar_old_valid(bar_old_valid)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0]  m [256];
    logic [31:0] eb [6];
    logic        ev [6];

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic ro_off(input int off);
        return (off <= 3) || (off >= 8 && off <= 11) || off == 14 || off == 61;
    endfunction

    function automatic logic [31:0] mword(input int dw);
        return {m[4*dw+3], m[4*dw+2], m[4*dw+1], m[4*dw]};
    endfunction

    // Expected decode from the requirements, in 64-bit arithmetic.
    task automatic exp_map(input int b, output logic [31:0] base, output logic v);
        longint unsigned sz, bb, last;
        logic ok;
        sz = 64'(SZ[b]);
        if (sz == 0) begin base = '0; v = 1'b0; return; end
        bb = 64'(mword(4 + b)) & ~(sz - 1) & 64'hFFFF_FFFF;
        last = bb + sz - 1;
        if (ISIO[b]) ok = m[4][0] && bb != 0 && last < 64'h1_0000;
        else         ok = m[4][1] && bb != 0 && last < 64'hFFFF_FFFF;
        v = ok;
        base = ok ? 32'(bb) : 32'h0;
    endtask

    task automatic rd_chk(input int dw, input string req);
        @(negedge clk);
        acc_dw = 6'(dw);
        #1;
        check(rd_data == mword(dw), req, rd_data, mword(dw));
    endtask

    task automatic wr(input int dw, input logic [3:0] be, input logic [31:0] d,
                      input string tag);
        logic hit, trig;
        logic [31:0] w, nb;
        logic nv;
        @(negedge clk);
        acc_wr = 1'b1; acc_dw = 6'(dw); acc_be = be; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0;
        hit = (be == 4'hF) && dw >= 4 && dw <= 9 && SZ[dw-4] != 0;
        if (hit) begin
            w = (d & ~(SZ[dw-4] - 1)) | {31'b0, ISIO[dw-4]};
            for (int k = 0; k < 4; k++) m[4*dw+k] = w[8*k +: 8];
        end else begin
            for (int k = 0; k < 4; k++)
                if (be[k] && !ro_off(4*dw+k)) m[4*dw+k] = d[8*k +: 8];
        end
        trig = hit || (dw == 1 && be[1:0] != 2'b00);
        @(negedge clk);
        for (int b = 0; b < 6; b++) begin
            logic chg;
            chg = 1'b0;
            if (trig) begin
                exp_map(b, nb, nv);
                chg = (nb != eb[b]) || (nv != ev[b]);
                if (chg) begin
                    check(bar_old_base[b] == eb[b], "R9", bar_old_base[b], eb[b]);
                    check(bar_old_valid[b] == ev[b], "R9", 32'(bar_old_valid[b]), 32'(ev[b]));
                end
                eb[b] = nb; ev[b] = nv;
            end
            check(bar_remap[b] == chg, "R9", 32'(bar_remap[b]), 32'(chg));
            check(bar_base[b] == eb[b], trig ? tag : "R8", bar_base[b], eb[b]);
            check(bar_valid[b] == ev[b], trig ? tag : "R8", 32'(bar_valid[b]), 32'(ev[b]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) m[i] = 8'h00;
        m[0] = P_VEN[7:0];  m[1] = P_VEN[15:8];
        m[2] = P_DEV[7:0];  m[3] = P_DEV[15:8];
        m[8] = P_REV;       m[9] = P_PIF;
        m[10] = P_CLS[7:0]; m[11] = P_CLS[15:8];
        m[14] = P_HDR;      m[61] = P_PIN;
        for (int b = 0; b < 6; b++) begin
            if (SZ[b] != 0 && ISIO[b]) m[16 + 4*b] = 8'h01;
            eb[b] = '0; ev[b] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every dword and of every mapping output
        for (int d = 0; d < 64; d++) rd_chk(d, "R1");
        for (int b = 0; b < 6; b++) begin
            check(bar_base[b] == 0, "R1", bar_base[b], 0);
            check(bar_valid[b] == 0, "R1", 32'(bar_valid[b]), 0);
            check(bar_remap[b] == 0, "R1", 32'(bar_remap[b]), 0);
        end

        // R2 R3 R4: every dword written with all ones, then read back
        for (int d = 0; d < 64; d++) wr(d, 4'hF, 32'hFFFF_FFFF, "R3");
        for (int d = 0; d < 64; d++) rd_chk(d, "R2");
        // R2 R4: varying partial enables and patterns over every dword
        for (int d = 0; d < 64; d++)
            wr(d, 4'(d + 1), 32'h0101_0101 * 32'(d) ^ 32'hA55A_3CC3, "R4");
        for (int d = 0; d < 64; d++) rd_chk(d, "R10");

        // Clear command, then drive BAR0 (I/O, 0x20) across its limits
        wr(1, 4'h3, 32'h0, "R5");
        wr(4, 4'hF, 32'h0000_1234, "R5");
        wr(1, 4'h1, 32'h1, "R5");
        rd_chk(4, "R3");
        wr(4, 4'hF, 32'h0000_FFF0, "R6");
        wr(4, 4'hF, 32'h0001_0000, "R6");
        wr(4, 4'hF, 32'h0000_0010, "R6");
        wr(4, 4'hF, 32'hFFFF_FFE0, "R6");
        wr(4, 4'hF, 32'h0000_C000, "R6");
        // BAR3 (I/O, 0x10) near the top of I/O space
        wr(7, 4'hF, 32'h0000_FFF3, "R6");
        rd_chk(7, "R3");
        // Memory enable alone: I/O windows drop, memory windows appear
        wr(1, 4'h3, 32'h2, "R5");
        wr(5, 4'hF, 32'hFFFF_F000, "R7");
        wr(5, 4'hF, 32'hFFFF_E123, "R7");
        rd_chk(5, "R3");
        wr(5, 4'hF, 32'h0000_0FFF, "R7");
        wr(8, 4'hF, 32'hFFF0_0000, "R7");
        wr(8, 4'hF, 32'hABCD_EF01, "R7");
        rd_chk(8, "R3");
        wr(1, 4'h1, 32'h3, "R5");
        // R4: partial BAR write stores bytes and does not recompute
        wr(5, 4'h4, 32'h0055_0000, "R4");
        rd_chk(5, "R4");
        wr(1, 4'h2, 32'h0000_0000, "R8");
        // R4: absent BAR stores verbatim, no recompute
        wr(6, 4'hF, 32'h1234_5678, "R4");
        rd_chk(6, "R4");
        wr(9, 4'hF, 32'h8765_4321, "R4");
        rd_chk(9, "R4");
        // Upper command bytes do not trigger
        wr(1, 4'hC, 32'hFFFF_0000, "R8");
        wr(1, 4'h1, 32'h0, "R5");
        // R2: dword with the interrupt pin byte
        wr(15, 4'hF, 32'hDEAD_BEEF, "R2");
        rd_chk(15, "R2");
        rd_chk(0, "R2");
        rd_chk(2, "R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule